// File: doc/BRIEF.md
# Early-Resolved Branch Fetch Controller

This block is the fetch front end of a five-stage in-order pipeline. It owns the program counter, reads instruction words from a small synchronous instruction store, and places each word, its address and a valid flag in the fetch/decode register. While a word sits in decode, the block also settles control transfers. A branch checks one register operand against zero, and a dedicated adder forms the target. The next fetch address is therefore chosen at the end of decode, and a redirect never costs more than one cycle.

A policy input selects how the slot behind a branch is treated. In squash policy, fetch runs on sequentially. A taken transfer turns the word already fetched behind it into a bubble, so it costs one lost cycle, and a not-taken branch costs none. In slot policy, the word after the branch always proceeds as a real instruction and the redirect follows it, so no cycle is lost. A downstream stall freezes the front end. A redirect decided during the stall is remembered and applied when the stall lifts. Two counters report completed control transfers and squashed slots. The register file read value arrives on an input, addressed by the source-select field that the block drives out. The instruction store is filled through a plain write port while the pipeline is held in reset.

Top module: `early_branch_fetch`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, clears the decode valid flag and clears both counters. The first word, from address 0, appears valid in decode one cycle after reset is released.
- R2: With no redirect and no stall, the fetch address grows by 4 each cycle. Each word enters decode valid one cycle after its address was issued, carrying that address and the stored word.
- R3: The instruction word has the opcode in bits [31:26], the source-register select in bits [25:21] and a 16-bit immediate in bits [15:0]. Opcode 0x04 is branch-if-zero, 0x05 is branch-if-nonzero and 0x02 is jump; every other opcode is not a control transfer. The target is the branch address plus 4, plus the sign-extended immediate shifted left by 2, and negative offsets go backward.
- R4: Branch-if-zero is taken exactly when the operand input equals zero. Branch-if-nonzero is taken exactly when the operand is nonzero. A jump is always taken.
- R5: In squash policy (policy input 0), a taken transfer in decode makes the next decode slot invalid and places the target in decode in the cycle after that. This is one lost cycle.
- R6: In squash policy, a not-taken branch is followed in decode by the word at its address plus 4 in the very next cycle, with no bubble.
- R7: In slot policy (policy input 1), the word after a branch always enters decode valid, taken or not. For a taken branch, the target follows in the next cycle.
- R8: An invalid (squashed) decode slot has no effect, even when it holds a control opcode. It causes no redirect and it is not counted as a branch.
- R9: While the stall input is high, the fetch address, the decode valid flag, the decode address and the decode word all hold their values.
- R10: A taken decision made during a stall is kept until the stall releases and is then acted on, even if the operand input changes meanwhile.
- R11: The branch counter rises by one for each valid control transfer that leaves decode. The squash counter rises by one for each slot that is turned into a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_mode | input | 1 | Policy: 0 squash behind taken transfers, 1 one always-executed slot |
| stall | input | 1 | Downstream hold; freezes fetch and decode |
| load_we | input | 1 | Instruction store write enable |
| load_addr | input | $clog2(IMEM_WORDS) | Word index written |
| load_data | input | 32 | Word written |
| rs_value | input | DATA_W | Register file value of the selected source |
| fetch_pc | output | 32 | Address currently being fetched |
| id_valid | output | 1 | Decode slot holds a real instruction |
| id_pc | output | 32 | Address of the decode word |
| id_insn | output | 32 | Decode word |
| rs_sel | output | 5 | Source-register select of the decode word |
| redirect_o | output | 1 | Fetch is redirected at the coming edge |
| redirect_target | output | 32 | Target address of the decode word |
| branch_count | output | CNT_W | Completed control transfers |
| squash_count | output | CNT_W | Slots turned into bubbles |

## Verification
The bench aims at the slot behind a taken transfer in both policies. A design that mixed them up would either run a wrong-path word in squash policy or drop a real slot instruction in slot policy. It also places a jump inside a squashed slot: a front end that resolved invalid words would jump a second time and count an extra branch. A stall lasting several cycles, with the operand changing from zero to nonzero partway through, exposes a design that re-evaluates the branch at release and so loses the redirect. A backward jump with a negative immediate catches a target adder that zero-extends the offset.

// File: rtl/ebf_pkg.sv
package ebf_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned RSEL_W = 5;

  // control-transfer opcodes, bits [31:26] of the word
  localparam logic [OPC_W-1:0] OPC_JUMP = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BRZ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNZ = 6'h05;

  localparam logic POLICY_SQUASH = 1'b0;
  localparam logic POLICY_SLOT   = 1'b1;

  typedef logic [PC_W-1:0] pc_t;

  function automatic pc_t seq_pc(pc_t pc);
    return pc + pc_t'(4);
  endfunction

  function automatic pc_t branch_target(pc_t pc, logic [IMM_W-1:0] imm);
    pc_t off;
    off = {{(PC_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    return seq_pc(pc) + off;
  endfunction

  function automatic logic is_ctrl(logic [OPC_W-1:0] opc);
    return (opc == OPC_JUMP) || (opc == OPC_BRZ) || (opc == OPC_BRNZ);
  endfunction

  function automatic logic ctrl_taken(logic [OPC_W-1:0] opc, logic operand_zero);
    logic t;
    case (opc)
      OPC_JUMP: t = 1'b1;
      OPC_BRZ:  t = operand_zero;
      OPC_BRNZ: t = !operand_zero;
      default:  t = 1'b0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/ebf_imem.sv
module ebf_imem #(
  parameter int unsigned WORDS  = 256,
  parameter int unsigned WIDTH  = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port: this register is the word half of fetch/decode
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ebf_branch_resolve.sv
module ebf_branch_resolve
  import ebf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              id_valid,
  input  logic [OPC_W-1:0]  id_opc,
  input  logic [IMM_W-1:0]  id_imm,
  input  pc_t               id_pc,
  input  logic [DATA_W-1:0] rs_value,
  output logic              redirect,
  output pc_t               redirect_pc,
  output logic              branch_done
);
  logic live_ctrl;
  logic live_taken;
  logic pend_q;

  assign live_ctrl   = id_valid && is_ctrl(id_opc);
  assign live_taken  = live_ctrl && ctrl_taken(id_opc, rs_value == '0);
  assign redirect_pc = branch_target(id_pc, id_imm);

  // the decode word is frozen during a stall, so only the decision is held
  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (stall) pend_q <= pend_q || live_taken;
    else            pend_q <= 1'b0;
  end

  assign redirect    = !stall && (pend_q || live_taken);
  assign branch_done = !stall && live_ctrl;

  p_pending_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (stall && live_taken) |=> (stall ? pend_q : redirect));

  p_jump_always_r4: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_opc == OPC_JUMP && !stall) |-> redirect);
endmodule

// File: rtl/ebf_pc_unit.sv
module ebf_pc_unit
  import ebf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic redirect,
  input  pc_t  redirect_pc,
  output pc_t  pc_q
);
  pc_t pc_d;

  always_comb begin
    pc_d = pc_q;
    if (advance) pc_d = redirect ? redirect_pc : seq_pc(pc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (advance && !redirect) |=> (pc_q == $past(pc_q) + pc_t'(4)));

  p_redirect_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && redirect) |=> (pc_q == $past(redirect_pc)));
endmodule

// File: rtl/ebf_event_count.sv
module ebf_event_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             branch_evt,
  input  logic             squash_evt,
  output logic [CNT_W-1:0] branch_cnt,
  output logic [CNT_W-1:0] squash_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      branch_cnt <= '0;
      squash_cnt <= '0;
    end else begin
      if (branch_evt) branch_cnt <= branch_cnt + 1'b1;
      if (squash_evt) squash_cnt <= squash_cnt + 1'b1;
    end
  end

  p_squash_counted_r11: assert property (@(posedge clk) disable iff (rst)
    squash_evt |=> (squash_cnt == CNT_W'($past(squash_cnt) + 1'b1)));

  p_branch_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !branch_evt |=> $stable(branch_cnt));
endmodule

// File: rtl/early_branch_fetch.sv
module early_branch_fetch
  import ebf_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 256,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot_mode,
  input  logic                          stall,
  input  logic                          load_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] load_addr,
  input  logic [31:0]                   load_data,
  input  logic [DATA_W-1:0]             rs_value,
  output logic [31:0]                   fetch_pc,
  output logic                          id_valid,
  output logic [31:0]                   id_pc,
  output logic [31:0]                   id_insn,
  output logic [4:0]                    rs_sel,
  output logic                          redirect_o,
  output logic [31:0]                   redirect_target,
  output logic [CNT_W-1:0]              branch_count,
  output logic [CNT_W-1:0]              squash_count
);
  localparam int unsigned IDX_W = $clog2(IMEM_WORDS);

  // named internal events
  logic advance;
  logic redirect;
  logic squash_now;
  logic branch_done;
  pc_t  pc_q;
  pc_t  redirect_pc;
  logic fd_valid_q;
  pc_t  fd_pc_q;
  logic [INSN_W-1:0] fd_insn;

  assign advance    = !stall;
  assign squash_now = advance && redirect && (slot_mode == POLICY_SQUASH);

  ebf_pc_unit u_pc (
    .clk         (clk),
    .rst         (rst),
    .advance     (advance),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .pc_q        (pc_q)
  );

  ebf_imem #(.WORDS(IMEM_WORDS), .WIDTH(INSN_W)) u_imem (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_data),
    .re    (advance),
    .raddr (pc_q[IDX_W+1:2]),
    .rdata (fd_insn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fd_valid_q <= 1'b0;
      fd_pc_q    <= '0;
    end else if (advance) begin
      fd_valid_q <= !squash_now;
      fd_pc_q    <= pc_q;
    end
  end

  ebf_branch_resolve #(.DATA_W(DATA_W)) u_resolve (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .id_valid    (fd_valid_q),
    .id_opc      (fd_insn[31:26]),
    .id_imm      (fd_insn[15:0]),
    .id_pc       (fd_pc_q),
    .rs_value    (rs_value),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .branch_done (branch_done)
  );

  ebf_event_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .branch_evt (branch_done),
    .squash_evt (squash_now),
    .branch_cnt (branch_count),
    .squash_cnt (squash_count)
  );

  assign fetch_pc        = pc_q;
  assign id_valid        = fd_valid_q;
  assign id_pc           = fd_pc_q;
  assign id_insn         = fd_insn;
  assign rs_sel          = fd_insn[25:21];
  assign redirect_o      = redirect;
  assign redirect_target = redirect_pc;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fetch_pc == '0 && !id_valid));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(fd_pc_q) && $stable(fd_valid_q) && $stable(fd_insn)));

  p_squash_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && redirect && !slot_mode) |=> !id_valid);

  p_slot_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && slot_mode) |=> id_valid);

  p_bubble_inert_r8: assert property (@(posedge clk) disable iff (rst)
    !fd_valid_q |-> (!redirect && !branch_done));
endmodule

// File: tb/sim_early_branch_fetch.sv
module sim_early_branch_fetch;
  localparam int IMW = 256;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_mode = 1'b0;
  logic stall = 1'b0;
  logic load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] rs_value = '0;
  logic [31:0] fetch_pc, id_pc, id_insn, redirect_target;
  logic        id_valid, redirect_o;
  logic [4:0]  rs_sel;
  logic [CW-1:0] branch_count, squash_count;

  int checks = 0;
  int fails  = 0;
  logic [31:0] img [IMW];

  always #2 clk = ~clk;

  early_branch_fetch #(.IMEM_WORDS(IMW), .CNT_W(CW), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .slot_mode(slot_mode), .stall(stall),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .rs_value(rs_value), .fetch_pc(fetch_pc), .id_valid(id_valid),
    .id_pc(id_pc), .id_insn(id_insn), .rs_sel(rs_sel),
    .redirect_o(redirect_o), .redirect_target(redirect_target),
    .branch_count(branch_count), .squash_count(squash_count)
  );

  function automatic logic [31:0] enc(logic [5:0] opc, logic [4:0] rs, logic [15:0] imm);
    return {opc, rs, 5'd0, imm};
  endfunction

  function automatic logic [31:0] tgt(logic [31:0] pc, logic [15:0] imm);
    int signed off;
    off = $signed(imm);
    return pc + 32'd4 + 32'(off * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_img();
    for (int i = 0; i < IMW; i++) img[i] = 32'h0;
  endtask

  task automatic boot(logic mode);
    rst = 1'b1;
    stall = 1'b0;
    slot_mode = mode;
    for (int i = 0; i < IMW; i++) begin
      load_we = 1'b1;
      load_addr = 8'(i);
      load_data = img[i];
      step();
    end
    load_we = 1'b0;
    step();
    rst = 1'b0;
  endtask

  task automatic expect_id(string req, logic v, logic [31:0] pc);
    step();
    check({req, " valid"}, 32'(id_valid), 32'(v));
    if (v) check({req, " pc"}, id_pc, pc);
  endtask

  // R1: reset state and first fetch
  task automatic t_reset();
    clear_img();
    img[0] = enc(6'h08, 5'd7, 16'h1234);
    boot(1'b0);
    check("R1 fetch_pc", fetch_pc, 32'h0);
    check("R1 id_valid", 32'(id_valid), 32'h0);
    check("R1 branch_count", 32'(branch_count), 32'h0);
    expect_id("R1 first", 1'b1, 32'h0);
    check("R1 first word", id_insn, img[0]);
    check("R3 rs_sel field", 32'(rs_sel), 32'd7);
    step(); step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 mid reset pc", fetch_pc, 32'h0);
    check("R1 mid reset valid", 32'(id_valid), 32'h0);
  endtask

  // R2: sequential flow, non-control opcode with immediate is not a branch
  task automatic t_sequential();
    clear_img();
    img[1] = enc(6'h08, 5'd3, 16'h0005);
    img[3] = enc(6'h06, 5'd1, 16'hFFFF);
    rs_value = 32'h0;
    boot(1'b0);
    for (int k = 0; k < 6; k++) begin
      expect_id("R2 seq", 1'b1, 32'(4 * k));
      check("R2 fetch_pc", fetch_pc, 32'(4 * k + 4));
      if (k == 1) check("R2 word", id_insn, img[1]);
      if (k == 1 || k == 3) check("R3 not control", 32'(redirect_o), 32'h0);
    end
    check("R11 no branches", 32'(branch_count), 32'h0);
  endtask

  // R5, R8: squash policy, taken branch-if-zero, a jump sits in the squashed slot
  task automatic t_squash_taken();
    clear_img();
    img[1] = enc(6'h04, 5'd2, 16'd3);
    img[2] = enc(6'h02, 5'd0, 16'd100);
    rs_value = 32'h0;
    boot(1'b0);
    expect_id("R5 pre", 1'b1, 32'h0);
    expect_id("R5 branch", 1'b1, 32'h4);
    check("R4 brz taken on zero", 32'(redirect_o), 32'h1);
    check("R3 target", redirect_target, tgt(32'h4, 16'd3));
    expect_id("R5 bubble", 1'b0, 32'h8);
    check("R5 fetch at target", fetch_pc, 32'd20);
    check("R8 squashed jump inert", 32'(redirect_o), 32'h0);
    expect_id("R5 target", 1'b1, 32'd20);
    expect_id("R5 after target", 1'b1, 32'd24);
    check("R11 branch count", 32'(branch_count), 32'h1);
    check("R11 squash count", 32'(squash_count), 32'h1);
  endtask

  // R6: squash policy, not-taken branch-if-nonzero
  task automatic t_squash_not_taken();
    clear_img();
    img[1] = enc(6'h05, 5'd2, 16'd3);
    rs_value = 32'h0;
    boot(1'b0);
    expect_id("R6 pre", 1'b1, 32'h0);
    expect_id("R6 branch", 1'b1, 32'h4);
    check("R4 brnz not taken on zero", 32'(redirect_o), 32'h0);
    expect_id("R6 no bubble", 1'b1, 32'h8);
    expect_id("R6 fall through", 1'b1, 32'hC);
    check("R11 branch count", 32'(branch_count), 32'h1);
    check("R11 squash none", 32'(squash_count), 32'h0);
  endtask

  // R7: slot policy, taken branch-if-nonzero
  task automatic t_slot_taken();
    clear_img();
    img[1] = enc(6'h05, 5'd2, 16'd3);
    rs_value = 32'h9;
    boot(1'b1);
    expect_id("R7 pre", 1'b1, 32'h0);
    expect_id("R7 branch", 1'b1, 32'h4);
    check("R4 brnz taken on nonzero", 32'(redirect_o), 32'h1);
    expect_id("R7 slot runs", 1'b1, 32'h8);
    expect_id("R7 target", 1'b1, 32'd20);
    expect_id("R7 after target", 1'b1, 32'd24);
    check("R11 squash none", 32'(squash_count), 32'h0);
  endtask

  // R7: slot policy, not-taken branch-if-zero
  task automatic t_slot_not_taken();
    clear_img();
    img[1] = enc(6'h04, 5'd2, 16'd3);
    rs_value = 32'h9;
    boot(1'b1);
    expect_id("R7 nt pre", 1'b1, 32'h0);
    expect_id("R7 nt branch", 1'b1, 32'h4);
    check("R4 brz not taken on nonzero", 32'(redirect_o), 32'h0);
    expect_id("R7 nt slot", 1'b1, 32'h8);
    expect_id("R7 nt next", 1'b1, 32'hC);
  endtask

  // R3: backward jump with negative immediate
  task automatic t_backward_jump();
    clear_img();
    img[3] = enc(6'h02, 5'd0, 16'hFFFD);
    rs_value = 32'h55;
    boot(1'b0);
    expect_id("R3 w0", 1'b1, 32'h0);
    expect_id("R3 w1", 1'b1, 32'h4);
    expect_id("R3 w2", 1'b1, 32'h8);
    expect_id("R3 jump", 1'b1, 32'hC);
    check("R3 backward target", redirect_target, tgt(32'hC, 16'hFFFD));
    expect_id("R5 jump bubble", 1'b0, 32'h10);
    expect_id("R3 landed", 1'b1, tgt(32'hC, 16'hFFFD));
    expect_id("R3 continue", 1'b1, tgt(32'hC, 16'hFFFD) + 32'd4);
  endtask

  // R9, R10: stall holds decode; a decision made during stall survives operand change
  task automatic t_stall();
    clear_img();
    img[1] = enc(6'h04, 5'd2, 16'd3);
    rs_value = 32'h0;
    boot(1'b0);
    expect_id("R9 pre", 1'b1, 32'h0);
    expect_id("R9 branch", 1'b1, 32'h4);
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9 held valid", 32'(id_valid), 32'h1);
      check("R9 held pc", id_pc, 32'h4);
      check("R9 held word", id_insn, img[1]);
      check("R9 held fetch", fetch_pc, 32'h8);
      if (k == 0) rs_value = 32'h5;
    end
    stall = 1'b0;
    expect_id("R10 bubble after release", 1'b0, 32'h8);
    check("R10 fetch at target", fetch_pc, 32'd20);
    expect_id("R10 target", 1'b1, 32'd20);
    check("R11 branch once", 32'(branch_count), 32'h1);
    check("R11 squash once", 32'(squash_count), 32'h1);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_squash_taken();
    t_squash_not_taken();
    t_slot_taken();
    t_slot_not_taken();
    t_backward_jump();
    t_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule